// File: doc/BRIEF.md
# Read Output Stage with Selectable Latency and Deselect Timing

This block sits between the storage array of a synchronous burst memory and its data pins. Each clock cycle it is given a decoded cycle code (read, write or deselect) and the word the array returns for that cycle. It produces the word to place on the data bus and a single drive-enable flag for the bus drivers. Two mode pins choose its timing. One selects zero-latency pass-through or one extra registered cycle. The other selects whether a deselect shuts the drivers off at once or one cycle later. An active-low output enable, asynchronous to the clock, can force the drivers off at any moment.

The driver timing comes from a two-state machine that records whether the previous cycle was a read. `LINK_QUIET` means no read was captured at the last edge. `LINK_RD_PEND` means one was. A read code moves the machine to `LINK_RD_PEND`, and any other code moves it to `LINK_QUIET`. Both transitions can happen from either state. In `LINK_QUIET` the drivers turn on only for a read in pass-through mode. In `LINK_RD_PEND` they turn on for a read. Under dual-cycle deselect they also stay on for a deselect code, showing the last word read. A write code always turns them off. The read word is held in one register, loaded on read cycles only. Registered mode always shows this register. Pass-through mode shows it only during the extra deselect cycle.

Top module: `rd_out_stage`

## Requirements
- R1: While reset is low, and after its release until the first read, `drive_en_o` is 0 and `dout_o` is all zeros.
- R2: The mode pins are captured only on rising edges while `rst_n` is low. `lat_sel_i` = 0 selects pass-through and 1 selects registered output. `desel_sel_i` = 0 selects dual-cycle deselect and 1 selects single-cycle deselect. Changing either pin after reset has no effect on timing.
- R3: In pass-through mode, a read cycle (`op_i` = 2'b01) drives `dout_o` = `arr_data_i` on all bits in that same cycle, with `drive_en_o` = 1.
- R4: In registered mode, the word presented in a read cycle appears on `dout_o` in the next cycle. The drivers are on in that next cycle only if it is a read, or a deselect under dual-cycle deselect. A read cycle that follows a non-read cycle is not driven.
- R5: In a write cycle (`op_i` = 2'b10), `drive_en_o` is 0 in every mode.
- R6: Under single-cycle deselect, a deselect cycle (`op_i` = 2'b00 or 2'b11) has `drive_en_o` = 0, in both latency modes.
- R7: Under dual-cycle deselect, a deselect cycle directly after a read keeps `drive_en_o` = 1 and shows the last word read. The next deselect cycle turns the drivers off.
- R8: `oe_n_i` = 1 forces `drive_en_o` to 0 at once, without waiting for a clock edge. `oe_n_i` = 0 enables the drivers only in cycles where R3, R4 or R7 provide read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; mode pins are captured while it is low |
| lat_sel_i | input | 1 | Latency mode pin: 0 pass-through, 1 registered |
| desel_sel_i | input | 1 | Deselect mode pin: 0 dual-cycle, 1 single-cycle |
| op_i | input | 2 | Cycle code: 00 deselect, 01 read, 10 write, 11 deselect |
| arr_data_i | input | DATA_W | Word returned by the array for this cycle |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| dout_o | output | DATA_W | Word for the data bus |
| drive_en_o | output | 1 | Bus drivers on when 1 |

## Verification
The assertions assume that `op_i` and `arr_data_i` change only between clock edges. They also assume the cycle code stays at deselect while reset is low, so the first cycle after reset starts from `LINK_QUIET` with nothing pending. The stimulus applies every input one time unit after a rising edge and holds the code at deselect throughout reset. Only the output enable is moved in the middle of a cycle, and that is done to exercise its asynchronous path. Mode pins are changed after reset only in the directed test that checks they are ignored.

// File: rtl/rd_out_pkg.sv
package rd_out_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_NOP   = 2'b11
    } cyc_op_e;

    typedef enum logic {
        LINK_QUIET   = 1'b0,
        LINK_RD_PEND = 1'b1
    } link_st_e;

    typedef struct packed {
        logic pipe;
        logic single_desel;
    } mode_t;

endpackage

// File: rtl/ros_mode_latch.sv
module ros_mode_latch
    import rd_out_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lat_sel_i,
    input  logic  desel_sel_i,
    output mode_t mode_o
);

    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q.pipe         <= lat_sel_i;
            mode_q.single_desel <= desel_sel_i;
        end
    end

    assign mode_o = mode_q;

    // R2: outside reset the captured mode never moves
    p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

endmodule

// File: rtl/ros_data_stage.sv
module ros_data_stage
    import rd_out_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_t             mode_i,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] arr_data_i,
    output logic [DATA_W-1:0] dout_o
);

    logic [DATA_W-1:0] word_q;
    logic              is_rd;

    assign is_rd = (op_i == OP_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (is_rd) begin
            word_q <= arr_data_i;
        end
    end

    generate
        if (DATA_W > 0) begin : g_out_mux
            always_comb begin
                if (!mode_i.pipe && is_rd) begin
                    dout_o = arr_data_i;
                end else begin
                    dout_o = word_q;
                end
            end
        end
    endgenerate

    // R4: registered mode shows the word of the previous read cycle
    p_pipe_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_i.pipe && $past(op_i == OP_READ))
            |-> (dout_o == $past(arr_data_i)));

endmodule

// File: rtl/ros_drive_ctl.sv
module ros_drive_ctl
    import rd_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mode_t      mode_i,
    input  logic [1:0] op_i,
    input  logic       oe_n_i,
    output logic       drive_en_o
);

    link_st_e st_q;
    link_st_e st_d;
    logic     is_rd;
    logic     is_des;
    logic     drv_raw;

    assign is_rd  = (op_i == OP_READ);
    assign is_des = (op_i == OP_IDLE) || (op_i == OP_NOP);

    always_comb begin
        st_d = is_rd ? LINK_RD_PEND : LINK_QUIET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LINK_QUIET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        drv_raw = 1'b0;
        unique case (st_q)
            LINK_QUIET:   drv_raw = !mode_i.pipe && is_rd;
            LINK_RD_PEND: drv_raw = is_rd || (is_des && !mode_i.single_desel);
            default:      drv_raw = 1'b0;
        endcase
    end

    assign drive_en_o = drv_raw && !oe_n_i;

    // R5: a write cycle never drives
    p_write_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_WRITE) |-> !drive_en_o);

    // R6: single-cycle deselect drives only on reads
    p_scd_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i.single_desel && op_i != OP_READ) |-> !drive_en_o);

    // R7: dual-cycle deselect holds the drivers one cycle after a read
    p_dcd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !mode_i.single_desel && $past(op_i == OP_READ)
         && (op_i == OP_IDLE) && !oe_n_i) |-> drive_en_o);

    // R8: a high enable wins at any time
    always_comb begin
        if (rst_n && oe_n_i) begin
            p_oe_gate_r8: assert (!drive_en_o);
        end
    end

endmodule

// File: rtl/rd_out_stage.sv
module rd_out_stage
    import rd_out_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_sel_i,
    input  logic              desel_sel_i,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] arr_data_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              drive_en_o
);

    mode_t mode;

    ros_mode_latch u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .lat_sel_i   (lat_sel_i),
        .desel_sel_i (desel_sel_i),
        .mode_o      (mode)
    );

    ros_data_stage #(.DATA_W(DATA_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .op_i       (op_i),
        .arr_data_i (arr_data_i),
        .dout_o     (dout_o)
    );

    ros_drive_ctl u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .op_i       (op_i),
        .oe_n_i     (oe_n_i),
        .drive_en_o (drive_en_o)
    );

    // R3: pass-through read drives the array word in the same cycle
    p_flow_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.pipe && op_i == OP_READ && !oe_n_i)
            |-> (drive_en_o && dout_o == arr_data_i));

endmodule

// File: tb/tb_rd_out_stage.sv
module tb_rd_out_stage;

    localparam int CLK_P = 10;
    localparam int DW    = 32;
    localparam int NVEC  = 10;

    // [21:20] op, [19:16] drive per mode {FS,FD,PS,PD}, [15:0] source index per mode
    localparam logic [21:0] VEC [NVEC] = '{
        {2'b00, 4'b0000, 16'h0000},
        {2'b01, 4'b1100, 16'h1100},
        {2'b01, 4'b1111, 16'h2211},
        {2'b00, 4'b0101, 16'h0202},
        {2'b00, 4'b0000, 16'h0000},
        {2'b01, 4'b1100, 16'h5500},
        {2'b10, 4'b0000, 16'h0000},
        {2'b01, 4'b1100, 16'h7700},
        {2'b11, 4'b0101, 16'h0707},
        {2'b00, 4'b0000, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lat_sel_i = 1'b0;
    logic          desel_sel_i = 1'b1;
    logic [1:0]    op_i = 2'b00;
    logic [DW-1:0] arr_data_i = '0;
    logic          oe_n_i = 1'b0;
    logic [DW-1:0] dout_o;
    logic          drive_en_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    rd_out_stage #(.DATA_W(DW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lat_sel_i   (lat_sel_i),
        .desel_sel_i (desel_sel_i),
        .op_i        (op_i),
        .arr_data_i  (arr_data_i),
        .oe_n_i      (oe_n_i),
        .dout_o      (dout_o),
        .drive_en_o  (drive_en_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [DW-1:0] dat(input int i);
        return 32'h1357_0100 + 32'(i);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic lat, input logic des);
        rst_n = 1'b0;
        lat_sel_i = lat;
        desel_sel_i = des;
        op_i = 2'b00;
        oe_n_i = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic cyc(input logic [1:0] op, input logic [DW-1:0] d);
        @(posedge clk);
        #1;
        op_i = op;
        arr_data_i = d;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 drive in reset", {31'd0, drive_en_o}, 32'd0);
        chk("R1 dout in reset", dout_o, 32'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 drive after reset", {31'd0, drive_en_o}, 32'd0);
        chk("R1 dout after reset", dout_o, 32'd0);

        // Vector table in all four modes: m=0 FS, 1 FD, 2 PS, 3 PD
        for (int m = 0; m < 4; m++) begin
            do_reset(m >= 2, (m == 0) || (m == 2));
            for (int i = 0; i < NVEC; i++) begin
                logic [1:0] op;
                logic       edrv;
                logic [3:0] src;
                string      tag;
                op   = VEC[i][21:20];
                edrv = VEC[i][19-m];
                src  = VEC[i][15-4*m -: 4];
                cyc(op, dat(i));
                if (op == 2'b01)      tag = (m < 2) ? "R3" : "R4";
                else if (op == 2'b10) tag = "R5";
                else                  tag = ((m == 0) || (m == 2)) ? "R6" : "R7";
                chk($sformatf("%s drive mode%0d cyc%0d", tag, m, i),
                    {31'd0, drive_en_o}, {31'd0, edrv});
                if (edrv) begin
                    chk($sformatf("%s data mode%0d cyc%0d", tag, m, i),
                        dout_o, dat(int'(src)));
                end
            end
        end

        // R8: asynchronous enable in registered dual-cycle mode
        do_reset(1'b1, 1'b0);
        cyc(2'b01, 32'hAAAA_0001);
        cyc(2'b01, 32'hAAAA_0002);
        chk("R8 drive before gate", {31'd0, drive_en_o}, 32'd1);
        chk("R4 word of earlier read", dout_o, 32'hAAAA_0001);
        #1 oe_n_i = 1'b1;
        #1 chk("R8 gated off mid-cycle", {31'd0, drive_en_o}, 32'd0);
        oe_n_i = 1'b0;
        #1 chk("R8 re-enabled mid-cycle", {31'd0, drive_en_o}, 32'd1);
        cyc(2'b00, 32'hDEAD_0000);
        chk("R7 hold after read", {31'd0, drive_en_o}, 32'd1);
        chk("R7 held word", dout_o, 32'hAAAA_0002);
        cyc(2'b00, 32'hDEAD_0001);
        chk("R8 no data no drive", {31'd0, drive_en_o}, 32'd0);

        // R8: enable high in pass-through read
        do_reset(1'b0, 1'b1);
        oe_n_i = 1'b1;
        cyc(2'b01, 32'hBBBB_0001);
        chk("R8 gated flow read", {31'd0, drive_en_o}, 32'd0);
        oe_n_i = 1'b0;
        #1 chk("R8 flow read enabled", {31'd0, drive_en_o}, 32'd1);

        // R2: mode pins moved after reset are ignored
        do_reset(1'b0, 1'b1);
        lat_sel_i = 1'b1;
        desel_sel_i = 1'b0;
        cyc(2'b00, 32'h0);
        cyc(2'b00, 32'h0);
        cyc(2'b01, 32'hCCCC_0001);
        chk("R2 still pass-through drive", {31'd0, drive_en_o}, 32'd1);
        chk("R2 still pass-through data", dout_o, 32'hCCCC_0001);
        cyc(2'b00, 32'h0);
        chk("R2 still single-cycle deselect", {31'd0, drive_en_o}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule